// File: doc/BRIEF.md
# Auto-Incrementing X/Y Display Address Counter

This block produces the address for a two-dimensional graphics memory organised as column words (X) and rows (Y). It holds a 5-bit X counter and a 7-bit Y counter. The host can load either counter directly. Each time a display-data read or write access completes, exactly one of the two counters steps by one. A single stored direction bit chooses which counter steps, so the next access sees the updated address without further host action.

The counters are plain binary counters that are wider than the valid address range. They run past the last valid column or row and wrap only at their full binary width. Software is expected to reload X or Y when a line or column is done. A combinational out-of-range flag reports when the current address lies outside the valid area. The address itself is still presented unchanged. The X limit depends on the word-length mode: the last valid X is 20 with 8-bit words and 27 with 6-bit words. The last valid Y is 64.

Top module: `xy_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on leaving reset, `x_addr` = 0, `y_addr` = 0 and the stored direction selects X (direction bit 0).
- R2: On a clock edge with `acc_done` = 1, direction 0 and no X load, `x_addr` becomes its old value + 1 and `y_addr` is unchanged. The new value is visible after that edge.
- R3: On a clock edge with `acc_done` = 1, direction 1 and no Y load, `y_addr` becomes its old value + 1 and `x_addr` is unchanged.
- R4: The X counter does not stop at 20 or 27. It steps on to 31 and wraps from 31 to 0.
- R5: The Y counter does not stop at 64. It steps on to 127 and wraps from 127 to 0.
- R6: `x_ld` = 1 loads `ld_val[4:0]` into X, and `y_ld` = 1 loads `ld_val[6:0]` into Y. A load wins over an increment of the same counter in the same cycle. The other counter still steps as the direction selects.
- R7: `dir_wr` = 1 stores `dir_sel` as the direction (0 = X steps, 1 = Y steps). The new direction applies from the next cycle. An access in the same cycle uses the previous direction.
- R8: `out_of_range` = 1 exactly when `y_addr` > 64, or `x_addr` > 20 with `word6` = 0, or `x_addr` > 27 with `word6` = 1. It follows `word6` and the counters without delay.
- R9: In a cycle with no access and no load, both counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_done | input | 1 | High in the cycle that completes a display-data read or write |
| x_ld | input | 1 | Load X from `ld_val[4:0]` |
| y_ld | input | 1 | Load Y from `ld_val` |
| ld_val | input | 7 | Load value for the counters |
| dir_wr | input | 1 | Write the increment-direction bit |
| dir_sel | input | 1 | Direction value to store: 0 = X, 1 = Y |
| word6 | input | 1 | Word-length mode: 0 = 8-bit words, 1 = 6-bit words |
| x_addr | output | 5 | Current column-word address |
| y_addr | output | 7 | Current row address |
| out_of_range | output | 1 | Current address outside the valid area |

## Verification
The bench walks X across both word-mode limits (20 to 21, and 27 to 28) and checks the flag on each side. A design that compared against the wrong limit, or used `>=` instead of `>`, would raise or drop the flag one step early or late. It steps X from 31 and Y from 127 to show the counters wrap at their binary width rather than at the valid limit; a saturating or limit-clamped counter would stick. It applies a load together with an access to confirm the load wins while the other counter still steps. It writes the direction in the same cycle as an access to show the old direction is still used; a design that forwarded the new bit would move the wrong counter.

// File: rtl/xy_addr_gen.sv
module xy_addr_gen #(
  parameter int XW      = 5,
  parameter int YW      = 7,
  parameter int X_LAST8 = 20,
  parameter int X_LAST6 = 27,
  parameter int Y_LAST  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_done,
  input  logic          x_ld,
  input  logic          y_ld,
  input  logic [YW-1:0] ld_val,
  input  logic          dir_wr,
  input  logic          dir_sel,
  input  logic          word6,
  output logic [XW-1:0] x_addr,
  output logic [YW-1:0] y_addr,
  output logic          out_of_range
);
  localparam logic [XW-1:0] XL8 = XW'(X_LAST8);
  localparam logic [XW-1:0] XL6 = XW'(X_LAST6);
  localparam logic [YW-1:0] YL  = YW'(Y_LAST);

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic          dir_q;
  logic [XW-1:0] x_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      dir_q <= 1'b0;
    end else begin
      if (x_ld)                   x_q <= ld_val[XW-1:0];
      else if (acc_done && !dir_q) x_q <= x_q + 1'b1;
      if (y_ld)                   y_q <= ld_val;
      else if (acc_done && dir_q)  y_q <= y_q + 1'b1;
      if (dir_wr)                 dir_q <= dir_sel;
    end
  end

  assign x_lim        = word6 ? XL6 : XL8;
  assign x_addr       = x_q;
  assign y_addr       = y_q;
  assign out_of_range = (x_q > x_lim) || (y_q > YL);
endmodule

module xy_addr_gen_chk #(
  parameter int XW = 5,
  parameter int YW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_done,
  input logic          x_ld,
  input logic          y_ld,
  input logic [YW-1:0] ld_val,
  input logic          dir_q,
  input logic          word6,
  input logic [XW-1:0] x_addr,
  input logic [YW-1:0] y_addr,
  input logic          out_of_range
);
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !dir_q && !x_ld) |=> x_addr == XW'($past(x_addr) + 1'b1)); // R2
  AST_Y_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && dir_q && !y_ld) |=> y_addr == YW'($past(y_addr) + 1'b1)); // R3
  AST_Y_STILL_ON_X: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !dir_q && !y_ld) |=> $stable(y_addr)); // R2
  AST_X_STILL_ON_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && dir_q && !x_ld) |=> $stable(x_addr)); // R3
  AST_X_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    x_ld |=> x_addr == $past(ld_val[XW-1:0])); // R6
  AST_Y_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    y_ld |=> y_addr == $past(ld_val)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_done && !x_ld && !y_ld) |=> ($stable(x_addr) && $stable(y_addr))); // R9
  AST_Y_HIGH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (y_addr > YW'(64)) |-> out_of_range); // R8
  AST_INSIDE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (y_addr <= YW'(64) && x_addr <= XW'(20)) |-> !out_of_range); // R8
endmodule

bind xy_addr_gen xy_addr_gen_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_done(acc_done), .x_ld(x_ld), .y_ld(y_ld),
  .ld_val(ld_val), .dir_q(dir_q), .word6(word6), .x_addr(x_addr),
  .y_addr(y_addr), .out_of_range(out_of_range)
);

// File: tb/xy_addr_gen_test.sv
module xy_addr_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_done = 1'b0, x_ld = 1'b0, y_ld = 1'b0;
  logic [6:0] ld_val = '0;
  logic       dir_wr = 1'b0, dir_sel = 1'b0, word6 = 1'b0;
  logic [4:0] x_addr;
  logic [6:0] y_addr;
  logic       out_of_range;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  xy_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .acc_done(acc_done), .x_ld(x_ld), .y_ld(y_ld),
    .ld_val(ld_val), .dir_wr(dir_wr), .dir_sel(dir_sel), .word6(word6),
    .x_addr(x_addr), .y_addr(y_addr), .out_of_range(out_of_range)
  );

  // fields: req(4) xl yl data(7) dwe dval mode acc | ex(5) ey(7) eoor
  localparam int NV = 20;
  localparam logic [29:0] VEC [NV] = '{
    {4'd2, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b0,1'b1, 5'd1,  7'd0,   1'b0}, // R2
    {4'd2, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b0,1'b1, 5'd2,  7'd0,   1'b0}, // R2
    {4'd6, 1'b1,1'b0,7'd19, 1'b0,1'b0,1'b0,1'b0, 5'd19, 7'd0,   1'b0}, // R6
    {4'd8, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b0,1'b1, 5'd20, 7'd0,   1'b0}, // R8
    {4'd8, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b0,1'b1, 5'd21, 7'd0,   1'b1}, // R8 R4
    {4'd9, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b1,1'b0, 5'd21, 7'd0,   1'b0}, // R9 R8
    {4'd6, 1'b1,1'b0,7'd27, 1'b0,1'b0,1'b1,1'b1, 5'd27, 7'd0,   1'b0}, // R6
    {4'd8, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b1,1'b1, 5'd28, 7'd0,   1'b1}, // R8
    {4'd6, 1'b1,1'b0,7'd31, 1'b0,1'b0,1'b1,1'b0, 5'd31, 7'd0,   1'b1}, // R6
    {4'd4, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b1,1'b1, 5'd0,  7'd0,   1'b0}, // R4
    {4'd7, 1'b0,1'b0,7'd0,  1'b1,1'b1,1'b0,1'b1, 5'd1,  7'd0,   1'b0}, // R7
    {4'd3, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b0,1'b1, 5'd1,  7'd1,   1'b0}, // R3
    {4'd6, 1'b0,1'b1,7'd64, 1'b0,1'b0,1'b0,1'b0, 5'd1,  7'd64,  1'b0}, // R6
    {4'd5, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b0,1'b1, 5'd1,  7'd65,  1'b1}, // R5 R8
    {4'd6, 1'b0,1'b1,7'd127,1'b0,1'b0,1'b0,1'b0, 5'd1,  7'd127, 1'b1}, // R6
    {4'd5, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b0,1'b1, 5'd1,  7'd0,   1'b0}, // R5
    {4'd6, 1'b0,1'b1,7'd5,  1'b0,1'b0,1'b0,1'b1, 5'd1,  7'd5,   1'b0}, // R6
    {4'd6, 1'b1,1'b0,7'd9,  1'b0,1'b0,1'b0,1'b1, 5'd9,  7'd6,   1'b0}, // R6 R3
    {4'd9, 1'b0,1'b0,7'd0,  1'b1,1'b0,1'b0,1'b0, 5'd9,  7'd6,   1'b0}, // R9 R7
    {4'd7, 1'b0,1'b0,7'd0,  1'b0,1'b0,1'b0,1'b1, 5'd10, 7'd6,   1'b0}  // R7
  };

  task automatic check(input string req, input logic [4:0] ex, input logic [6:0] ey,
                       input logic eo);
    checks++;
    if (x_addr !== ex || y_addr !== ey || out_of_range !== eo) begin
      errors++;
      $display("FAIL %s: x=%0d y=%0d oor=%0b expected x=%0d y=%0d oor=%0b",
               req, x_addr, y_addr, out_of_range, ex, ey, eo);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1", 5'd0, 7'd0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {x_ld, y_ld, ld_val, dir_wr, dir_sel, word6, acc_done} = VEC[i][25:13];
      tick();
      check($sformatf("R%0d vec%0d", VEC[i][29:26], i),
            VEC[i][12:8], VEC[i][7:1], VEC[i][0]);
    end
    {x_ld, y_ld, ld_val, dir_wr, dir_sel, word6, acc_done} = '0;

    // R9: several idle cycles hold the address
    for (int k = 0; k < 4; k++) tick();
    check("R9", 5'd10, 7'd6, 1'b0);

    // R8: flag follows word mode with no clock edge in between
    x_ld = 1'b1; ld_val = 7'd24; tick(); x_ld = 1'b0;
    check("R8", 5'd24, 7'd6, 1'b1);
    word6 = 1'b1; #1;
    check("R8", 5'd24, 7'd6, 1'b0);
    word6 = 1'b0;

    // R1: mid-run reset clears counters and direction
    dir_wr = 1'b1; dir_sel = 1'b1; tick(); dir_wr = 1'b0;
    rst_n = 1'b0; acc_done = 1'b1; tick();
    check("R1", 5'd0, 7'd0, 1'b0);
    rst_n = 1'b1; tick(); acc_done = 1'b0;
    check("R1", 5'd1, 7'd0, 1'b0);

    // R2/R6: Y load while X steps
    acc_done = 1'b1; y_ld = 1'b1; ld_val = 7'd70; tick();
    acc_done = 1'b0; y_ld = 1'b0;
    check("R6", 5'd2, 7'd70, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule